// File: doc/BRIEF.md
# Alarm Interrupt and Square-Wave Output Unit

This block sits next to a real-time clock's timekeeping counters and drives two low-active, open-drain-style output pins. It holds two alarm settings and compares each of them against the current BCD seconds, minutes and hours. The comparison happens once per second tick. A match raises a sticky alarm flag in a status register, and software clears the flag by writing 0 to it.

A control register holds an interrupt enable for each alarm, a routing bit and a two-bit rate code. With the routing bit at 0, both enabled alarms share pin A, and pin B carries a square wave. That wave is either a copy of a 32.768 kHz oscillator level supplied by the surrounding chip or a division of it. With the routing bit at 1, alarm 1 drives pin A and alarm 2 drives pin B, and the square wave is not used.

Each pin is presented as a drive enable (`*_oe`, 1 = pull the line low) together with the resulting line level (`*_n`). Register access is a single-cycle write port and a combinational read port.

Top module: `alm_irq_sqw`

## Requirements
- R1: After reset, the control register (address 0x0E) reads 0x18 and the status register (address 0x0F) reads 0x00. The control fields are: bit0 alarm-1 enable, bit1 alarm-2 enable, bit2 routing, bits4:3 rate. Neither pin A nor pin B is driven by an alarm.
- R2: The alarm-1 setting is held at 0x07 (seconds), 0x08 (minutes) and 0x09 (hours). When a tick arrives with all three fields equal to the current time, status bit0 is 1 from the next cycle onward.
- R3: A flag does not set when the time matches without a tick, or when a tick arrives with any compared field unequal.
- R4: The alarm-2 setting is held at 0x0B (minutes) and 0x0C (hours). Alarm 2 matches only when the current seconds are 0x00, and it sets status bit1. In either alarm, bit7 of a setting byte set to 1 makes that field always match.
- R5: Flags are sticky. A status write with 0 in a flag bit clears that flag. A 1 in the bit leaves the flag unchanged.
- R6: If a status write clears a flag in the same cycle that a tick-qualified match sets it, the flag ends up set.
- R7: With the routing bit at 1, pin A is driven exactly while alarm-1 is flagged and enabled, and pin B exactly while alarm-2 is flagged and enabled.
- R8: With the routing bit at 0, pin A is driven while either alarm is flagged and enabled, and pin B is driven while the square wave is low.
- R9: A set flag whose enable bit is 0 does not drive any pin.
- R10: A pin releases in the cycle that follows the status write clearing its flag, which is the same cycle in which the flag reads 0.
- R11: Rate codes 3, 2, 1 and 0 select the following square waves: the oscillator level registered once, bit1 of a count of oscillator rising edges (8.192 kHz), bit2 of that count (4.096 kHz), and bit14 of that count (1 Hz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_sec | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, raw hour-register byte |
| osc_32k | input | 1 | 32.768 kHz oscillator level, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (0 for unmapped addresses) |
| pin_a_n | output | 1 | Pin A line level, low when driven |
| pin_a_oe | output | 1 | Pin A pull-down enable |
| pin_b_n | output | 1 | Pin B line level, low when driven |
| pin_b_oe | output | 1 | Pin B pull-down enable |

## Verification
A tick-qualified alarm match and a software write that clears the same flag can fall in the same cycle. The bench provokes this by raising `tick_sec` with a matching time during the same cycle as a status write of 0. It then expects the flag still set and pin A still driven, because the new event must not be lost. The bench also runs the square wave through each rate code with the oscillator toggling every cycle, and it predicts each pin-B level from its own count of rising edges.

// File: rtl/alm_pkg.sv
package alm_pkg;

    parameter int ADDR_W = 4;
    parameter int DATA_W = 8;
    parameter int DIV_W  = 15;
    parameter int N_ALM  = 2;

    localparam int TAP_8K = 1;
    localparam int TAP_4K = 2;
    localparam int TAP_1HZ = DIV_W - 1;

    localparam logic [ADDR_W-1:0] ADR_A1_SEC  = 4'h7;
    localparam logic [ADDR_W-1:0] ADR_A1_MIN  = 4'h8;
    localparam logic [ADDR_W-1:0] ADR_A1_HOUR = 4'h9;
    localparam logic [ADDR_W-1:0] ADR_A2_MIN  = 4'hB;
    localparam logic [ADDR_W-1:0] ADR_A2_HOUR = 4'hC;
    localparam logic [ADDR_W-1:0] ADR_CTRL    = 4'hE;
    localparam logic [ADDR_W-1:0] ADR_STAT    = 4'hF;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] hour;
    } bcd_time_t;

    typedef enum logic [1:0] {
        RATE_1HZ = 2'b00,
        RATE_4K  = 2'b01,
        RATE_8K  = 2'b10,
        RATE_32K = 2'b11
    } rate_e;

    typedef struct packed {
        rate_e rate;
        logic  route_sep;
        logic  a2_ie;
        logic  a1_ie;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_RST = '{rate: RATE_32K, route_sep: 1'b0,
                                   a2_ie: 1'b0, a1_ie: 1'b0};

    // bit7 of a setting byte masks the field
    function automatic logic field_hit(input logic [DATA_W-1:0] setv,
                                       input logic [DATA_W-1:0] now);
        return setv[DATA_W-1] || (setv[DATA_W-2:0] == now[DATA_W-2:0]);
    endfunction

endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output bcd_time_t         set_q [N_ALM]
);

    bcd_time_t a1_q;
    logic [DATA_W-1:0] a2_min_q, a2_hour_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= CTRL_RST;
            a1_q      <= '0;
            a2_min_q  <= '0;
            a2_hour_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_CTRL:    ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
                ADR_A1_SEC:  a1_q.sec  <= wr_data;
                ADR_A1_MIN:  a1_q.min  <= wr_data;
                ADR_A1_HOUR: a1_q.hour <= wr_data;
                ADR_A2_MIN:  a2_min_q  <= wr_data;
                ADR_A2_HOUR: a2_hour_q <= wr_data;
                default: ;
            endcase
        end
    end

    // alarm 2 has no seconds setting: it compares against 00, unmasked
    always_comb begin
        set_q[0] = a1_q;
        set_q[1] = '{sec: '0, min: a2_min_q, hour: a2_hour_q};
    end

    a_r1_ctrl_reset: assert property (@(posedge clk)
        rst |=> (ctrl == CTRL_RST));

endmodule

// File: rtl/alm_match.sv
module alm_match
    import alm_pkg::*;
(
    input  bcd_time_t now,
    input  bcd_time_t setting,
    output logic      hit
);

    always_comb begin
        hit = field_hit(setting.sec,  now.sec)
            & field_hit(setting.min,  now.min)
            & field_hit(setting.hour, now.hour);
    end

endmodule

// File: rtl/alm_flags.sv
module alm_flags
    import alm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [N_ALM-1:0] hit,
    input  logic             stat_we,
    input  logic [N_ALM-1:0] stat_wd,
    output logic [N_ALM-1:0] flag
);

    for (genvar i = 0; i < N_ALM; i++) begin : g_flag
        logic clr, set;
        assign clr = stat_we & ~stat_wd[i];
        assign set = tick & hit[i];

        always_ff @(posedge clk) begin
            if (rst)        flag[i] <= 1'b0;
            else if (set)   flag[i] <= 1'b1;
            else if (clr)   flag[i] <= 1'b0;
        end

        // R5: only a 0-write may drop a flag
        a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
            (flag[i] && !(stat_we && !stat_wd[i])) |=> flag[i]);

        // R2/R3: a flag rises only after a tick
        a_r3_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
            $rose(flag[i]) |-> $past(tick));

        // R6: set beats clear
        a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
            (tick && hit[i]) |=> flag[i]);
    end

endmodule

// File: rtl/alm_sqw_div.sv
module alm_sqw_div
    import alm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  osc,
    input  rate_e rate,
    output logic  sqw
);

    logic             osc_q;
    logic             rise;
    logic [DIV_W-1:0] cnt;

    assign rise = osc & ~osc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            osc_q <= 1'b0;
            cnt   <= '0;
        end else begin
            osc_q <= osc;
            if (rise) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        unique case (rate)
            RATE_32K: sqw = osc_q;
            RATE_8K:  sqw = cnt[TAP_8K];
            RATE_4K:  sqw = cnt[TAP_4K];
            default:  sqw = cnt[TAP_1HZ];
        endcase
    end

    a_r11_count_holds: assert property (@(posedge clk) disable iff (rst)
        !(osc && !osc_q) |=> $stable(cnt));

endmodule

// File: rtl/alm_irq_sqw.sv
module alm_irq_sqw
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_sec,
    input  logic [DATA_W-1:0] cur_sec,
    input  logic [DATA_W-1:0] cur_min,
    input  logic [DATA_W-1:0] cur_hour,
    input  logic              osc_32k,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pin_a_n,
    output logic              pin_a_oe,
    output logic              pin_b_n,
    output logic              pin_b_oe
);

    ctrl_t            ctrl;
    bcd_time_t        set_q [N_ALM];
    bcd_time_t        now;
    logic [N_ALM-1:0] hit;
    logic [N_ALM-1:0] flag;
    logic [N_ALM-1:0] live;
    logic             sqw;

    assign now = '{sec: cur_sec, min: cur_min, hour: cur_hour};

    alm_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .set_q(set_q)
    );

    for (genvar i = 0; i < N_ALM; i++) begin : g_match
        alm_match u_match (.now(now), .setting(set_q[i]), .hit(hit[i]));
    end

    alm_flags u_flags (
        .clk(clk), .rst(rst), .tick(tick_sec), .hit(hit),
        .stat_we(wr_en && wr_addr == ADR_STAT),
        .stat_wd(wr_data[N_ALM-1:0]), .flag(flag)
    );

    alm_sqw_div u_div (
        .clk(clk), .rst(rst), .osc(osc_32k), .rate(ctrl.rate), .sqw(sqw)
    );

    assign live = flag & {ctrl.a2_ie, ctrl.a1_ie};

    always_comb begin
        if (ctrl.route_sep) begin
            pin_a_oe = live[0];
            pin_b_oe = live[1];
        end else begin
            pin_a_oe = |live;
            pin_b_oe = ~sqw;
        end
        pin_a_n = ~pin_a_oe;
        pin_b_n = ~pin_b_oe;
    end

    always_comb begin
        unique case (rd_addr)
            ADR_A1_SEC:  rd_data = set_q[0].sec;
            ADR_A1_MIN:  rd_data = set_q[0].min;
            ADR_A1_HOUR: rd_data = set_q[0].hour;
            ADR_A2_MIN:  rd_data = set_q[1].min;
            ADR_A2_HOUR: rd_data = set_q[1].hour;
            ADR_CTRL:    rd_data = DATA_W'(ctrl);
            ADR_STAT:    rd_data = DATA_W'(flag);
            default:     rd_data = '0;
        endcase
    end

    // R9: with both enables low, no alarm can pull pin A
    a_r9_gate: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.a1_ie && !ctrl.a2_ie) |-> !pin_a_oe);

    // R7: separate routing, pin B follows alarm 2 only
    a_r7_pin_b: assert property (@(posedge clk) disable iff (rst)
        (ctrl.route_sep && !(flag[1] && ctrl.a2_ie)) |-> !pin_b_oe);

endmodule

// File: tb/alm_irq_sqw_tb.sv
`timescale 1ns/1ps
module alm_irq_sqw_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_sec = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0;
    logic       osc_32k = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pin_a_n, pin_a_oe, pin_b_n, pin_b_oe;

    always #2.5 clk = ~clk;

    alm_irq_sqw u_dut (
        .clk(clk), .rst(rst), .tick_sec(tick_sec), .cur_sec(cur_sec),
        .cur_min(cur_min), .cur_hour(cur_hour), .osc_32k(osc_32k),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .pin_a_n(pin_a_n),
        .pin_a_oe(pin_a_oe), .pin_b_n(pin_b_n), .pin_b_oe(pin_b_oe)
    );

    typedef struct {
        string      req;
        logic       ea;
        logic       eb;
        bit         chk_rd;
        logic [7:0] erd;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (pin_a_oe !== it.ea || pin_b_oe !== it.eb ||
                pin_a_n !== ~it.ea || pin_b_n !== ~it.eb ||
                (it.chk_rd && rd_data !== it.erd)) begin
                errors++;
                $display("FAIL %s: a_oe=%b b_oe=%b rd=%h expected a_oe=%b b_oe=%b rd=%h",
                         it.req, pin_a_oe, pin_b_oe, rd_data, it.ea, it.eb, it.erd);
            end
        end
    end

    task automatic expect_rd(input string req, input logic ea, input logic eb,
                             input logic [3:0] ra, input logic [7:0] erd);
        item_t it;
        rd_addr = ra;
        it = '{req: req, ea: ea, eb: eb, chk_rd: 1'b1, erd: erd};
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic tick(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        cur_hour = h; cur_min = m; cur_sec = s; tick_sec = 1'b1;
        @(posedge clk); #1;
        tick_sec = 1'b0;
    endtask

    // oscillator running; bench keeps its own edge count and level
    int   edges = 0;
    logic lvl = 1'b0;

    task automatic run_sqw(input string req, input logic [1:0] rate, input bit sep,
                           input int n);
        for (int k = 0; k < n; k++) begin
            item_t it;
            logic sq;
            case (rate)
                2'b11: sq = lvl;
                2'b10: sq = edges[1];
                2'b01: sq = edges[2];
                default: sq = edges[14];
            endcase
            it = '{req: req, ea: 1'b0, eb: sep ? 1'b0 : ~sq, chk_rd: 1'b0, erd: 8'h00};
            q.push_back(it);
            lvl = ~lvl;
            if (lvl) edges++;
            osc_32k = lvl;
            @(posedge clk); #1;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // osc low at reset, rate 32k, shared routing -> pin B driven
        expect_rd("R1 ctrl reset", 1'b0, 1'b1, 4'hE, 8'h18);
        expect_rd("R1 status reset", 1'b0, 1'b1, 4'hF, 8'h00);

        wr(4'h7, 8'h56); wr(4'h8, 8'h34); wr(4'h9, 8'h12);
        wr(4'hE, 8'h1C);                      // separate routing, no enables
        expect_rd("R2 alarm1 hour readback", 1'b0, 1'b0, 4'h9, 8'h12);
        tick(8'h12, 8'h34, 8'h55);
        expect_rd("R3 mismatch tick", 1'b0, 1'b0, 4'hF, 8'h00);
        cur_sec = 8'h56;
        @(posedge clk); #1;
        expect_rd("R3 match without tick", 1'b0, 1'b0, 4'hF, 8'h00);
        tick(8'h12, 8'h34, 8'h56);
        expect_rd("R2 alarm1 flag", 1'b0, 1'b0, 4'hF, 8'h01);
        expect_rd("R9 disabled flag no pin", 1'b0, 1'b0, 4'hF, 8'h01);
        wr(4'hE, 8'h1D);
        expect_rd("R7 alarm1 on pin A", 1'b1, 1'b0, 4'hF, 8'h01);
        wr(4'hF, 8'h01);
        expect_rd("R5 write 1 keeps", 1'b1, 1'b0, 4'hF, 8'h01);
        wr(4'hF, 8'h00);
        expect_rd("R10 clear releases pin", 1'b0, 1'b0, 4'hF, 8'h00);

        wr(4'hB, 8'h80); wr(4'hC, 8'h07);
        wr(4'hE, 8'h1E);                      // separate, alarm 2 enabled
        tick(8'h07, 8'h15, 8'h30);
        expect_rd("R4 alarm2 needs sec 00", 1'b0, 1'b0, 4'hF, 8'h00);
        tick(8'h07, 8'h15, 8'h00);
        expect_rd("R7 alarm2 on pin B", 1'b0, 1'b1, 4'hF, 8'h02);
        wr(4'hF, 8'h00);
        expect_rd("R5 clear alarm2", 1'b0, 1'b0, 4'hF, 8'h00);
        tick(8'h07, 8'h42, 8'h00);
        expect_rd("R4 masked minutes", 1'b0, 1'b1, 4'hF, 8'h02);
        wr(4'hF, 8'h00);
        wr(4'h7, 8'h80);
        tick(8'h12, 8'h34, 8'h17);
        expect_rd("R4 masked seconds alarm1", 1'b0, 1'b0, 4'hF, 8'h01);

        wr(4'hE, 8'h1B);                      // shared, both enabled, osc low
        expect_rd("R8 shared alarm1 on A", 1'b1, 1'b1, 4'hF, 8'h01);
        wr(4'hF, 8'h02);
        expect_rd("R10 shared released", 1'b0, 1'b1, 4'hF, 8'h00);
        tick(8'h07, 8'h42, 8'h00);
        expect_rd("R8 shared alarm2 on A", 1'b1, 1'b1, 4'hF, 8'h02);

        // collision: clear write and matching tick in the same cycle
        wr_en = 1'b1; wr_addr = 4'hF; wr_data = 8'h00;
        cur_hour = 8'h07; cur_min = 8'h42; cur_sec = 8'h00; tick_sec = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; tick_sec = 1'b0;
        expect_rd("R6 set wins over clear", 1'b1, 1'b1, 4'hF, 8'h02);
        wr(4'hF, 8'h00);
        expect_rd("R5 cleared after collision", 1'b0, 1'b1, 4'hF, 8'h00);

        wr(4'hE, 8'h18);
        run_sqw("R11 rate 32k", 2'b11, 1'b0, 20);
        wr(4'hE, 8'h10);
        run_sqw("R11 rate 8k", 2'b10, 1'b0, 40);
        wr(4'hE, 8'h08);
        run_sqw("R11 rate 4k", 2'b01, 1'b0, 60);
        wr(4'hE, 8'h04);
        run_sqw("R7 pin B quiet while separate", 2'b11, 1'b1, 20);
        wr(4'hE, 8'h00);
        run_sqw("R11 rate 1Hz", 2'b00, 1'b0, 33000);

        @(posedge clk); #1;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule